// File: doc/BRIEF.md
# Prescaled Up-Counter with Software Compare Channel

This block is a 32-bit timer that sits on a simple single-cycle register bus. The core clock feeds a power-of-two prescaler. Each prescaler tick advances an up-counter, which returns to zero after it reaches a programmable limit. A single compare channel watches the counter. When the channel is set to software compare, it raises a sticky event flag in the cycle the counter steps onto the programmed compare value. Software clears the flag by writing a one to it. An enable bit gates a level interrupt output driven by the flag.

Software typically stops the counter, clears it, and sets the limit to all ones so the counter runs freely. It then starts counting with a divider, reads the counter as a timebase, and programs the compare value to the current count plus a delay to get a one-shot event. The channel is built around a three-state machine:
- `CH_IDLE`: flag clear, channel not in compare mode.
- `CH_ARMED`: flag clear, compare mode selected.
- `CH_HIT`: flag set.

The machine has these transitions:
- `IDLE->ARMED`: compare mode is written.
- `ARMED->IDLE`: compare mode is left.
- `IDLE/ARMED->HIT`: a match occurs in compare mode.
- `HIT->ARMED` or `HIT->IDLE`: a clearing write arrives with no coincident match. The target depends on the current mode.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero except the limit register (offset 0x18), which reads 0xFFFFFFFF. The interrupt output is low.
- R2: Counting is enabled by bit 3 of the control register at offset 0x10. While that bit is 0, the counter holds its value.
- R3: Bits 2:0 of the control register give a shift p. While counting is enabled, the counter advances once every 2^p core clock cycles. The first step comes 2^p cycles after counting starts.
- R4: Any write to the counter register (offset 0x14) clears the counter to zero, whatever the data, and restarts the prescaler from zero. A read returns the live count.
- R5: When the counter steps while equal to the limit register (offset 0x18), it goes to zero instead of incrementing.
- R6: The channel control register is at offset 0x20, with the mode in bits 5:2. Only mode code 0x4 sets the event flag, which is bit 0 of the status register at offset 0x1C. The flag sets in the same cycle that the counter steps onto the value in the compare register (offset 0x24). Codes such as 0x0 and 0x5 never set it.
- R7: The event flag stays set until a status write with data bit 0 equal to 1. A status write with bit 0 equal to 0 leaves the flag unchanged.
- R8: If a clearing status write and a new match fall in the same cycle, the flag remains set.
- R9: The interrupt output is a level equal to the event flag AND bit 6 of the channel control register.
- R10: The limit and compare registers read back the written value. Reads return zero when the read strobe is low or the offset is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Channel interrupt, level |

## Verification
The counter is driven at dividers 1 and 4:
- Step counts that land just before and on a prescaler boundary separate a correct divider from an off-by-one one.
- A counter clear issued mid-period exposes a prescaler that is not restarted.

A small limit is crossed to show the wrap lands on zero rather than one.

The compare channel is tried in several ways:
- With the interrupt enabled and masked.
- With mode codes 0x0 and 0x5, which must never flag, against 0x4, which must.
- With a clearing write placed exactly on a match cycle, which tells a "clear wins" design from a "set wins" one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_COUNT = 'h14;
    localparam int OFS_LIMIT = 'h18;
    localparam int OFS_STAT  = 'h1C;
    localparam int OFS_CHCTL = 'h20;
    localparam int OFS_CVAL  = 'h24;

    // prescaler shift field width and the derived divider counter width
    localparam int PS_W  = 3;
    localparam int DIV_W = (1 << PS_W) - 1;

    localparam logic [3:0] MODE_SWCMP = 4'h4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_HIT   = 2'd2
    } ch_state_t;

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              flag,
    output logic              ctrl_en,
    output logic [PS_W-1:0]   ctrl_ps,
    output logic              ch_ie,
    output logic [3:0]        ch_mode,
    output logic [DATA_W-1:0] limit_val,
    output logic [DATA_W-1:0] cval_val,
    output logic              cnt_clr,
    output logic              flag_clr
);

    logic hit_ctrl, hit_count, hit_limit, hit_stat, hit_chctl, hit_cval;

    always_comb begin
        hit_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        hit_count = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
        hit_limit = bus_wr && (bus_addr == ADDR_W'(OFS_LIMIT));
        hit_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
        hit_chctl = bus_wr && (bus_addr == ADDR_W'(OFS_CHCTL));
        hit_cval  = bus_wr && (bus_addr == ADDR_W'(OFS_CVAL));
    end

    assign cnt_clr  = hit_count;
    assign flag_clr = hit_stat && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_ps   <= '0;
            ch_ie     <= 1'b0;
            ch_mode   <= '0;
            limit_val <= '1;
            cval_val  <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl_en <= bus_wdata[3];
                ctrl_ps <= bus_wdata[PS_W-1:0];
            end
            if (hit_chctl) begin
                ch_ie   <= bus_wdata[6];
                ch_mode <= bus_wdata[5:2];
            end
            if (hit_limit) limit_val <= bus_wdata;
            if (hit_cval)  cval_val  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if      (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = DATA_W'({ctrl_en, ctrl_ps});
            else if (bus_addr == ADDR_W'(OFS_COUNT)) bus_rdata = cnt_val;
            else if (bus_addr == ADDR_W'(OFS_LIMIT)) bus_rdata = limit_val;
            else if (bus_addr == ADDR_W'(OFS_STAT))  bus_rdata = DATA_W'(flag);
            else if (bus_addr == ADDR_W'(OFS_CHCTL)) bus_rdata = DATA_W'({ch_ie, ch_mode, 2'b00});
            else if (bus_addr == ADDR_W'(OFS_CVAL))  bus_rdata = cval_val;
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    input  logic            restart,
    output logic            tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;

    // limit is 2^ps - 1: all ones shifted down
    assign div_lim = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
    assign tick    = en && !restart && (div_q >= div_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || !en || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit_val,
    input  logic [CNT_W-1:0] cval_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);

    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = (cnt_q == limit_val) ? '0 : cnt_q + 1'b1;
    assign match  = tick && !clr && (cnt_nx == cval_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic [3:0] mode,
    input  logic       ie,
    input  logic       flag_clr,
    output logic       flag,
    output logic       irq
);

    ch_state_t state_q, state_d;
    logic      cmp_on, fire;

    assign cmp_on = (mode == MODE_SWCMP);
    assign fire   = cmp_on && match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (fire)        state_d = CH_HIT;
                else if (cmp_on) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (fire)         state_d = CH_HIT;
                else if (!cmp_on) state_d = CH_IDLE;
            end
            CH_HIT: begin
                if (flag_clr && !fire) state_d = cmp_on ? CH_ARMED : CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == CH_HIT);
        irq  = flag && ie;
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    logic             ctrl_en, ch_ie, cnt_clr, flag_clr, tick, match, flag;
    logic [PS_W-1:0]  ctrl_ps;
    logic [3:0]       ch_mode;
    logic [CNT_W-1:0] limit_val, cval_val, cnt_q;

    tmr_regfile #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt_q), .flag(flag),
        .ctrl_en(ctrl_en), .ctrl_ps(ctrl_ps),
        .ch_ie(ch_ie), .ch_mode(ch_mode),
        .limit_val(limit_val), .cval_val(cval_val),
        .cnt_clr(cnt_clr), .flag_clr(flag_clr)
    );

    tmr_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .ps(ctrl_ps),
        .restart(cnt_clr), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
        .limit_val(limit_val), .cval_val(cval_val),
        .cnt_q(cnt_q), .match(match)
    );

    tmr_channel u_ch (
        .clk(clk), .rst_n(rst_n), .match(match), .mode(ch_mode),
        .ie(ch_ie), .flag_clr(flag_clr), .flag(flag), .irq(irq)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             cnt_clr,
    input logic             flag_clr,
    input logic             tick,
    input logic             match,
    input logic             flag,
    input logic             ch_ie,
    input logic [3:0]       ch_mode,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] limit_val,
    input logic             irq
);

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !cnt_clr) |=> $stable(cnt_q));

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && cnt_q == limit_val) |=> (cnt_q == '0));

    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(ch_mode) == MODE_SWCMP && $past(match)));

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R8
    flag_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && match && ch_mode == MODE_SWCMP) |=> flag);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ch_ie));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ch_ie) |-> irq);

endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cnt_clr(cnt_clr),
    .flag_clr(flag_clr), .tick(tick), .match(match), .flag(flag),
    .ch_ie(ch_ie), .ch_mode(ch_mode), .cnt_q(cnt_q),
    .limit_val(limit_val), .irq(irq)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;

    localparam logic [7:0] A_CTRL  = 8'h10;
    localparam logic [7:0] A_COUNT = 8'h14;
    localparam logic [7:0] A_LIMIT = 8'h18;
    localparam logic [7:0] A_STAT  = 8'h1C;
    localparam logic [7:0] A_CHCTL = 8'h20;
    localparam logic [7:0] A_CVAL  = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        rd_reg(a, got);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic expect_irq(input logic exp, input string req);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic t_reset;
        expect_reg(A_CTRL,  32'h0, "R1");
        expect_reg(A_COUNT, 32'h0, "R1");
        expect_reg(A_LIMIT, 32'hFFFF_FFFF, "R1");
        expect_reg(A_STAT,  32'h0, "R1");
        expect_reg(A_CHCTL, 32'h0, "R1");
        expect_reg(A_CVAL,  32'h0, "R1");
        expect_irq(1'b0, "R1");
        wait_cyc(10);
        expect_reg(A_COUNT, 32'h0, "R2 stopped at reset");
    endtask

    task automatic t_div1;
        wr_reg(A_CTRL, 32'h08);
        wait_cyc(5);
        expect_reg(A_COUNT, 32'd5, "R3 divide by 1");
        wr_reg(A_CTRL, 32'h0);           // last step lands on this edge
        wait_cyc(5);
        expect_reg(A_COUNT, 32'd6, "R2 hold when disabled");
    endtask

    task automatic t_div4_clear;
        wr_reg(A_COUNT, 32'hDEAD_BEEF);
        expect_reg(A_COUNT, 32'd0, "R4 clear with any data");
        wr_reg(A_CTRL, 32'h0A);
        wait_cyc(13);
        expect_reg(A_COUNT, 32'd3, "R3 divide by 4");
        wr_reg(A_COUNT, 32'h1);
        wait_cyc(3);
        expect_reg(A_COUNT, 32'd0, "R4 prescaler restart");
        wait_cyc(1);
        expect_reg(A_COUNT, 32'd1, "R4 first step after clear");
    endtask

    task automatic t_wrap;
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_COUNT, 32'h0);
        wr_reg(A_LIMIT, 32'd5);
        expect_reg(A_LIMIT, 32'd5, "R10 limit readback");
        wr_reg(A_CTRL, 32'h08);
        wait_cyc(5);
        expect_reg(A_COUNT, 32'd5, "R5 at limit");
        wait_cyc(1);
        expect_reg(A_COUNT, 32'd0, "R5 wrap to zero");
        wait_cyc(2);
        expect_reg(A_COUNT, 32'd2, "R5 after wrap");
        wr_reg(A_LIMIT, 32'hFFFF_FFFF);
    endtask

    task automatic t_compare;
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_COUNT, 32'h0);
        wr_reg(A_CVAL, 32'd7);
        expect_reg(A_CVAL, 32'd7, "R10 compare readback");
        wr_reg(A_CHCTL, 32'h50);         // mode 0x4, interrupt enabled
        wr_reg(A_CTRL, 32'h08);
        wait_cyc(6);
        expect_reg(A_STAT, 32'h0, "R6 before match");
        expect_irq(1'b0, "R9 before match");
        wait_cyc(1);
        expect_reg(A_COUNT, 32'd7, "R6 match count");
        expect_reg(A_STAT, 32'h1, "R6 flag on match");
        expect_irq(1'b1, "R9 irq on match");
        wait_cyc(20);
        expect_reg(A_STAT, 32'h1, "R7 sticky");
        wr_reg(A_STAT, 32'h0);
        expect_reg(A_STAT, 32'h1, "R7 zero write ignored");
        wr_reg(A_STAT, 32'h1);
        expect_reg(A_STAT, 32'h0, "R7 write one clears");
        expect_irq(1'b0, "R9 irq drops");
    endtask

    task automatic t_masked;
        logic [31:0] c;
        wr_reg(A_CHCTL, 32'h10);         // mode 0x4, interrupt off
        rd_reg(A_COUNT, c);
        wr_reg(A_CVAL, c + 32'd5);
        wait_cyc(3);
        expect_reg(A_STAT, 32'h0, "R6 not yet");
        wait_cyc(1);
        expect_reg(A_STAT, 32'h1, "R6 flag while masked");
        expect_irq(1'b0, "R9 masked");
        wr_reg(A_CHCTL, 32'h50);
        expect_irq(1'b1, "R9 unmask raises irq");
    endtask

    task automatic t_race;
        logic [31:0] c;
        rd_reg(A_COUNT, c);
        wr_reg(A_CVAL, c + 32'd4);
        wait_cyc(2);
        wr_reg(A_STAT, 32'h1);           // clear on the match edge
        expect_reg(A_STAT, 32'h1, "R8 match beats clear");
        wr_reg(A_STAT, 32'h1);
        expect_reg(A_STAT, 32'h0, "R7 clear after race");
    endtask

    task automatic t_modes;
        logic [31:0] c;
        wr_reg(A_CHCTL, 32'h54);         // mode 0x5
        rd_reg(A_COUNT, c);
        wr_reg(A_CVAL, c + 32'd3);
        wait_cyc(6);
        expect_reg(A_STAT, 32'h0, "R6 mode 5 no flag");
        expect_irq(1'b0, "R6 mode 5 no irq");
        wr_reg(A_CHCTL, 32'h40);         // mode 0x0
        rd_reg(A_COUNT, c);
        wr_reg(A_CVAL, c + 32'd3);
        wait_cyc(6);
        expect_reg(A_STAT, 32'h0, "R6 mode 0 no flag");
        wr_reg(A_CHCTL, 32'h50);
        rd_reg(A_COUNT, c);
        wr_reg(A_CVAL, c + 32'd3);
        wait_cyc(2);
        expect_reg(A_STAT, 32'h1, "R6 mode 4 flags");
        expect_reg(A_8, 32'h0, "R10 unmapped");
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_div1();
        t_div4_clear();
        t_wrap();
        t_compare();
        t_masked();
        t_race();
        t_modes();
        total++;
        bus_addr = A_LIMIT;
        #1 if (bus_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R10 read without strobe actual=%h expected=%h", bus_rdata, 32'h0);
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [7:0] A_8 = 8'h08;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule